// File: doc/BRIEF.md
# Predicated Saturating MAC Lane Array

This block is a row of identical integer arithmetic lanes for a wide SIMD neural datapath. Each cycle every lane takes an activation byte (from the activation bus or from a forwarded-value bus) and a weight byte. It turns them into signed operands and folds the result of one shared operation into its own 32-bit accumulator. All lanes share one set of operation controls. Each lane keeps its own accumulator and its own bank of eight predicate bits.

In 9-bit mode, a programmable zero point is subtracted from each unsigned byte, which gives a signed value in -255..255. In 16-bit mode, each even lane joins its own byte and its odd neighbour's byte into one signed 16-bit operand and skips the zero-point step. The odd lane of each pair then sits idle. Accumulation never wraps: a result outside the 32-bit signed range is clamped. Predicate bits record the sign of the accumulator. A later operation can then be made conditional on one of them, which supports masked updates such as ReLU-like clamping or per-lane selection.

All accumulators are presented together on one flat output bus, one cycle after the operation that produced them.

Top module: `mac_lane_array`

## Requirements
- R1: While reset is active, every accumulator reads zero and every predicate bit is zero.
- R2: In 9-bit mode, each operand is the unsigned byte minus its zero point (activation zero point for activation, weight zero point for weight). The MAC operation (op code 1) adds the product of the two operands to the accumulator, and the new value appears on the output after one clock edge.
- R3: In 16-bit mode, even lane 2k uses {byte[2k+1], byte[2k]} as a signed 16-bit operand for both activation and weight, with no zero point subtracted. Odd lanes keep their accumulators unchanged.
- R4: Any result above 2^31-1 is written as 2^31-1, and any result below -2^31 is written as -2^31. The accumulator never wraps.
- R5: When the clear input is high, the operation uses zero in place of the old accumulator. With the no-op code (0) this loads zero, and with MAC it loads the product alone.
- R6: Op code 2 adds the activation operand, 3 subtracts it, 4 keeps the signed minimum of accumulator and operand, and 5 keeps the signed maximum. The weight is ignored for all four.
- R7: Op code 6 is a bitwise AND and op code 7 a bitwise OR of the accumulator with the sign-extended activation operand.
- R8: Op code 0 with clear low leaves the accumulator unchanged.
- R9: A predicate write stores into the predicate bit named by the write index the result of comparing the accumulator value held before that edge against zero. The compare code is 0 for greater, 1 for equal, 2 for less and 3 for not equal.
- R10: With predication enabled, a lane updates its accumulator only if its selected predicate bit differs from the polarity input. Otherwise the accumulator holds. The bit read is the value held before the same edge's predicate write.
- R11: With the forward-select input high, activation bytes come from the forwarded bus instead of the activation bus. Weights are unaffected.
- R12: Lane i's accumulator appears on bits [32i+31:32i] of the output, and all lanes update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation code (0 none, 1 MAC, 2 add, 3 sub, 4 min, 5 max, 6 and, 7 or) |
| clr_i | input | 1 | Use zero in place of the old accumulator |
| mode16_i | input | 1 | 1 selects 16-bit pair operands, 0 selects 9-bit zero-pointed operands |
| src_fwd_i | input | 1 | Take activation bytes from the forwarded bus |
| zp_act_i | input | 8 | Activation zero point |
| zp_wgt_i | input | 8 | Weight zero point |
| act_i | input | LANES*8 | Activation bytes, lane i at [8i+7:8i] |
| fwd_i | input | LANES*8 | Forwarded activation bytes |
| wgt_i | input | LANES*8 | Weight bytes |
| pred_wr_i | input | 1 | Write one predicate bit in every lane |
| pred_wr_idx_i | input | 3 | Predicate bit to write |
| pred_cond_i | input | 2 | Compare code for the write |
| pred_en_i | input | 1 | Make this cycle's update conditional |
| pred_sel_i | input | 3 | Predicate bit tested |
| pred_neg_i | input | 1 | Polarity: update when selected bit differs from this |
| acc_o | output | LANES*32 | All accumulators, lane i at [32i+31:32i] |

## Verification
A wrong operand, product or clamp shows up on the lane's slice of the accumulator bus on the very next edge. The bench therefore compares every lane in every cycle against an arithmetic model. A corrupted predicate bit is invisible until an operation is made conditional on it. The bench therefore sets bits from accumulators of known sign and then issues a gated add, so a bad bit appears as a held or a moved accumulator one edge later. Saturation faults only appear after several large 16-bit products have piled up, so those sequences are run until both clamps are reached and then pushed further.

// File: rtl/mac_lane_pkg.sv
package mac_lane_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_MAC = 3'd1,
    OP_ADD = 3'd2,
    OP_SUB = 3'd3,
    OP_MIN = 3'd4,
    OP_MAX = 3'd5,
    OP_AND = 3'd6,
    OP_OR  = 3'd7
  } lane_op_e;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_EQ = 2'd1,
    CMP_LT = 2'd2,
    CMP_NE = 2'd3
  } pred_cmp_e;

endpackage

// File: rtl/mac_operand.sv
module mac_operand #(
  parameter int BYTE_W = 8,
  parameter int OPD_W  = 2 * BYTE_W + 1
) (
  input  logic                    mode16_i,
  input  logic [BYTE_W-1:0]       lo_i,
  input  logic [BYTE_W-1:0]       hi_i,
  input  logic [BYTE_W-1:0]       zp_i,
  output logic signed [OPD_W-1:0] opd_o
);

  logic signed [BYTE_W:0] diff;

  always_comb begin
    diff = $signed({1'b0, lo_i}) - $signed({1'b0, zp_i});
    if (mode16_i) begin
      opd_o = {{(OPD_W - 2 * BYTE_W){hi_i[BYTE_W-1]}}, hi_i, lo_i};
    end else begin
      opd_o = {{(OPD_W - BYTE_W - 1){diff[BYTE_W]}}, diff};
    end
  end

endmodule

// File: rtl/mac_alu.sv
module mac_alu
  import mac_lane_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OPD_W = 17
) (
  input  lane_op_e                op_i,
  input  logic [ACC_W-1:0]        base_i,
  input  logic signed [OPD_W-1:0] act_i,
  input  logic signed [OPD_W-1:0] wgt_i,
  output logic [ACC_W-1:0]        res_o
);

  localparam int PROD_W = 2 * OPD_W;
  localparam int WIDE_W = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 2;
  localparam logic signed [WIDE_W-1:0] SAT_HI =
    {{(WIDE_W - ACC_W + 1){1'b0}}, {(ACC_W - 1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] SAT_LO =
    {{(WIDE_W - ACC_W + 1){1'b1}}, {(ACC_W - 1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [WIDE_W-1:0] base_w;
  logic signed [WIDE_W-1:0] act_w;
  logic signed [WIDE_W-1:0] prod_w;
  logic signed [WIDE_W-1:0] wide;
  logic [ACC_W-1:0]         act_acc;
  logic [ACC_W-1:0]         bits;

  always_comb begin
    prod    = act_i * wgt_i;
    base_w  = {{(WIDE_W - ACC_W){base_i[ACC_W-1]}}, base_i};
    act_w   = {{(WIDE_W - OPD_W){act_i[OPD_W-1]}}, act_i};
    prod_w  = {{(WIDE_W - PROD_W){prod[PROD_W-1]}}, prod};
    act_acc = {{(ACC_W - OPD_W){act_i[OPD_W-1]}}, act_i};
    bits    = '0;
    unique case (op_i)
      OP_NOP: wide = base_w;
      OP_MAC: wide = base_w + prod_w;
      OP_ADD: wide = base_w + act_w;
      OP_SUB: wide = base_w - act_w;
      OP_MIN: wide = (act_w < base_w) ? act_w : base_w;
      OP_MAX: wide = (act_w > base_w) ? act_w : base_w;
      OP_AND: begin
        bits = base_i & act_acc;
        wide = {{(WIDE_W - ACC_W){bits[ACC_W-1]}}, bits};
      end
      default: begin
        bits = base_i | act_acc;
        wide = {{(WIDE_W - ACC_W){bits[ACC_W-1]}}, bits};
      end
    endcase
  end

  always_comb begin
    if (wide > SAT_HI) begin
      res_o = {1'b0, {(ACC_W - 1){1'b1}}};
    end else if (wide < SAT_LO) begin
      res_o = {1'b1, {(ACC_W - 1){1'b0}}};
    end else begin
      res_o = wide[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/mac_pred.sv
module mac_pred
  import mac_lane_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int NPRED = 8,
  parameter int IDX_W = $clog2(NPRED)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  pred_cmp_e        cmp_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic             neg_i,
  output logic             pass_o,
  output logic [NPRED-1:0] pred_o
);

  logic [NPRED-1:0] pred_q;
  logic [NPRED-1:0] pred_d;
  logic             is_neg;
  logic             is_zero;
  logic             cmp_res;

  always_comb begin
    is_neg  = acc_i[ACC_W-1];
    is_zero = (acc_i == '0);
    unique case (cmp_i)
      CMP_GT:  cmp_res = !is_neg && !is_zero;
      CMP_EQ:  cmp_res = is_zero;
      CMP_LT:  cmp_res = is_neg;
      default: cmp_res = !is_zero;
    endcase
  end

  always_comb begin
    pred_d = pred_q;
    if (wr_i) begin
      pred_d[wr_idx_i] = cmp_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
    end else if (wr_i) begin
      pred_q <= pred_d;
    end
  end

  assign pass_o = !en_i || (pred_q[sel_i] ^ neg_i);
  assign pred_o = pred_q;

endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import mac_lane_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OPD_W = 17,
  parameter int NPRED = 8,
  parameter int IDX_W = $clog2(NPRED)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active_i,
  input  lane_op_e                op_i,
  input  logic                    clr_i,
  input  logic signed [OPD_W-1:0] act_i,
  input  logic signed [OPD_W-1:0] wgt_i,
  input  logic                    pred_wr_i,
  input  logic [IDX_W-1:0]        pred_wr_idx_i,
  input  pred_cmp_e               pred_cmp_i,
  input  logic                    pred_en_i,
  input  logic [IDX_W-1:0]        pred_sel_i,
  input  logic                    pred_neg_i,
  output logic [ACC_W-1:0]        acc_o,
  output logic [NPRED-1:0]        pred_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] alu_res;
  logic             pass;
  logic             acc_en;

  mac_pred #(
    .ACC_W(ACC_W),
    .NPRED(NPRED),
    .IDX_W(IDX_W)
  ) u_pred (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_i    (acc_q),
    .wr_i     (pred_wr_i),
    .wr_idx_i (pred_wr_idx_i),
    .cmp_i    (pred_cmp_i),
    .en_i     (pred_en_i),
    .sel_i    (pred_sel_i),
    .neg_i    (pred_neg_i),
    .pass_o   (pass),
    .pred_o   (pred_o)
  );

  mac_alu #(
    .ACC_W(ACC_W),
    .OPD_W(OPD_W)
  ) u_alu (
    .op_i   (op_i),
    .base_i (base),
    .act_i  (act_i),
    .wgt_i  (wgt_i),
    .res_o  (alu_res)
  );

  always_comb begin
    base   = clr_i ? '0 : acc_q;
    acc_en = active_i && pass;
    acc_d  = alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/mac_lane_array.sv
module mac_lane_array
  import mac_lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 32,
  parameter int NPRED  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                op_i,
  input  logic                      clr_i,
  input  logic                      mode16_i,
  input  logic                      src_fwd_i,
  input  logic [BYTE_W-1:0]         zp_act_i,
  input  logic [BYTE_W-1:0]         zp_wgt_i,
  input  logic [LANES*BYTE_W-1:0]   act_i,
  input  logic [LANES*BYTE_W-1:0]   fwd_i,
  input  logic [LANES*BYTE_W-1:0]   wgt_i,
  input  logic                      pred_wr_i,
  input  logic [$clog2(NPRED)-1:0]  pred_wr_idx_i,
  input  logic [1:0]                pred_cond_i,
  input  logic                      pred_en_i,
  input  logic [$clog2(NPRED)-1:0]  pred_sel_i,
  input  logic                      pred_neg_i,
  output logic [LANES*ACC_W-1:0]    acc_o
);

  localparam int OPD_W = 2 * BYTE_W + 1;
  localparam int IDX_W = $clog2(NPRED);

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  lane_op_e  op_e;
  pred_cmp_e cmp_e;
  assign op_e  = lane_op_e'(op_i);
  assign cmp_e = pred_cmp_e'(pred_cond_i);

  logic [BYTE_W-1:0]       act_sel [LANES];
  logic [LANES*NPRED-1:0]  pred_all;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit IS_EVEN = ((g % 2) == 0);

    logic [BYTE_W-1:0]       act_hi;
    logic [BYTE_W-1:0]       wgt_hi;
    logic                    active;
    logic signed [OPD_W-1:0] act_opd;
    logic signed [OPD_W-1:0] wgt_opd;

    assign act_sel[g] = src_fwd_i ? fwd_i[g*BYTE_W +: BYTE_W]
                                  : act_i[g*BYTE_W +: BYTE_W];

    if (IS_EVEN) begin : g_even
      assign act_hi = act_sel[g+1];
      assign wgt_hi = wgt_i[(g+1)*BYTE_W +: BYTE_W];
      assign active = 1'b1;
    end else begin : g_odd
      assign act_hi = '0;
      assign wgt_hi = '0;
      assign active = !mode16_i;
    end

    mac_operand #(
      .BYTE_W(BYTE_W),
      .OPD_W (OPD_W)
    ) u_act_opd (
      .mode16_i (mode16_i),
      .lo_i     (act_sel[g]),
      .hi_i     (act_hi),
      .zp_i     (zp_act_i),
      .opd_o    (act_opd)
    );

    mac_operand #(
      .BYTE_W(BYTE_W),
      .OPD_W (OPD_W)
    ) u_wgt_opd (
      .mode16_i (mode16_i),
      .lo_i     (wgt_i[g*BYTE_W +: BYTE_W]),
      .hi_i     (wgt_hi),
      .zp_i     (zp_wgt_i),
      .opd_o    (wgt_opd)
    );

    mac_lane #(
      .ACC_W(ACC_W),
      .OPD_W(OPD_W),
      .NPRED(NPRED),
      .IDX_W(IDX_W)
    ) u_lane (
      .clk           (clk),
      .rst_n         (rst_sync_n),
      .active_i      (active),
      .op_i          (op_e),
      .clr_i         (clr_i),
      .act_i         (act_opd),
      .wgt_i         (wgt_opd),
      .pred_wr_i     (pred_wr_i),
      .pred_wr_idx_i (pred_wr_idx_i),
      .pred_cmp_i    (cmp_e),
      .pred_en_i     (pred_en_i),
      .pred_sel_i    (pred_sel_i),
      .pred_neg_i    (pred_neg_i),
      .acc_o         (acc_o[g*ACC_W +: ACC_W]),
      .pred_o        (pred_all[g*NPRED +: NPRED])
    );
  end

endmodule

// File: rtl/mac_lane_array_chk.sv
module mac_lane_array_chk #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 32,
  parameter int NPRED  = 8
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic [2:0]               op_i,
  input logic                     clr_i,
  input logic                     mode16_i,
  input logic                     src_fwd_i,
  input logic [BYTE_W-1:0]        zp_act_i,
  input logic [BYTE_W-1:0]        act0_i,
  input logic                     pred_en_i,
  input logic [$clog2(NPRED)-1:0] pred_sel_i,
  input logic                     pred_neg_i,
  input logic [LANES*NPRED-1:0]   pred_all,
  input logic [LANES*ACC_W-1:0]   acc_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (acc_o == '0 && pred_all == '0));

  // R8
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd0 && !clr_i) |=> $stable(acc_o));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd0 && clr_i && !pred_en_i) |=> (acc_o[ACC_W-1:0] == '0));

  // R4
  add_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd2 && !clr_i && !pred_en_i && !mode16_i && !src_fwd_i &&
     act0_i >= zp_act_i)
    |=> ($signed(acc_o[ACC_W-1:0]) >= $signed($past(acc_o[ACC_W-1:0]))));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R10
    pred_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pred_en_i && (pred_all[g*NPRED + int'(pred_sel_i)] == pred_neg_i))
      |=> $stable(acc_o[g*ACC_W +: ACC_W]));

    if ((g % 2) == 1) begin : g_odd_chk
      // R3
      odd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        mode16_i |=> (acc_o[g*ACC_W +: ACC_W] == $past(acc_o[g*ACC_W +: ACC_W])));
    end
  end

endmodule

bind mac_lane_array mac_lane_array_chk #(
  .LANES (LANES),
  .BYTE_W(BYTE_W),
  .ACC_W (ACC_W),
  .NPRED (NPRED)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_i       (op_i),
  .clr_i      (clr_i),
  .mode16_i   (mode16_i),
  .src_fwd_i  (src_fwd_i),
  .zp_act_i   (zp_act_i),
  .act0_i     (act_i[BYTE_W-1:0]),
  .pred_en_i  (pred_en_i),
  .pred_sel_i (pred_sel_i),
  .pred_neg_i (pred_neg_i),
  .pred_all   (pred_all),
  .acc_o      (acc_o)
);

// File: tb/mac_lane_array_bench.sv
`timescale 1ns/1ps
module mac_lane_array_bench;
  localparam int LANES = 4;
  localparam int AW    = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [2:0] op;
  logic       clr, mode16, src_fwd, pred_wr, pen, pneg;
  logic [7:0] zpa, zpw;
  logic [2:0] pwi, psel;
  logic [1:0] pcond;
  logic [7:0] act_b [LANES];
  logic [7:0] wgt_b [LANES];
  logic [7:0] fwd_b [LANES];
  logic [LANES*8-1:0]  act_f, wgt_f, fwd_f;
  logic [LANES*AW-1:0] acc;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      act_f[i*8 +: 8] = act_b[i];
      wgt_f[i*8 +: 8] = wgt_b[i];
      fwd_f[i*8 +: 8] = fwd_b[i];
    end
  end

  mac_lane_array u_mac_lane_array (
    .clk(clk), .rst_n(rst_n), .op_i(op), .clr_i(clr), .mode16_i(mode16),
    .src_fwd_i(src_fwd), .zp_act_i(zpa), .zp_wgt_i(zpw), .act_i(act_f),
    .fwd_i(fwd_f), .wgt_i(wgt_f), .pred_wr_i(pred_wr), .pred_wr_idx_i(pwi),
    .pred_cond_i(pcond), .pred_en_i(pen), .pred_sel_i(psel),
    .pred_neg_i(pneg), .acc_o(acc)
  );

  longint     macc  [LANES];
  logic [7:0] mpred [LANES];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req;

  function automatic longint sat(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  task automatic idle();
    op = 3'd0; clr = 0; mode16 = 0; src_fwd = 0; pred_wr = 0; pen = 0; pneg = 0;
    zpa = 0; zpw = 0; pwi = 0; psel = 0; pcond = 0;
    for (int i = 0; i < LANES; i++) begin
      act_b[i] = 0; wgt_b[i] = 0; fwd_b[i] = 0;
    end
  endtask

  task automatic model_step();
    logic [7:0] src [LANES];
    longint nacc [LANES];
    for (int i = 0; i < LANES; i++) src[i] = src_fwd ? fwd_b[i] : act_b[i];
    for (int i = 0; i < LANES; i++) begin
      bit gate, active, cr;
      longint base, a, w, r;
      nacc[i] = macc[i];
      gate   = !pen || (mpred[i][psel] ^ pneg);
      active = !mode16 || (i % 2 == 0);
      if (active && gate) begin
        base = clr ? 0 : macc[i];
        if (mode16) begin
          a = longint'($signed({src[i+1], src[i]}));
          w = longint'($signed({wgt_b[i+1], wgt_b[i]}));
        end else begin
          a = longint'(src[i]) - longint'(zpa);
          w = longint'(wgt_b[i]) - longint'(zpw);
        end
        case (op)
          3'd0: r = base;
          3'd1: r = base + a * w;
          3'd2: r = base + a;
          3'd3: r = base - a;
          3'd4: r = (a < base) ? a : base;
          3'd5: r = (a > base) ? a : base;
          3'd6: r = base & a;
          default: r = base | a;
        endcase
        nacc[i] = sat(r);
      end
      if (pred_wr) begin
        case (pcond)
          2'd0: cr = macc[i] > 0;
          2'd1: cr = macc[i] == 0;
          2'd2: cr = macc[i] < 0;
          default: cr = macc[i] != 0;
        endcase
        mpred[i][pwi] = cr;
      end
    end
    for (int i = 0; i < LANES; i++) macc[i] = nacc[i];
  endtask

  task automatic check_all();
    for (int i = 0; i < LANES; i++) begin
      longint got;
      got = longint'($signed(acc[i*AW +: AW]));
      checks++;
      if (got != macc[i]) begin
        errors++;
        $display("FAIL %s lane %0d: got %0d expected %0d", req, i, got, macc[i]);
      end
    end
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    check_all();
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle();
    for (int i = 0; i < LANES; i++) begin macc[i] = 0; mpred[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    req = "R1 reset state"; check_all();

    // R1: predicates reset to zero, so a gate needing a set bit blocks
    req = "R1 R10 predicates clear after reset";
    op = 3'd2; zpa = 0; pen = 1; psel = 3'd5; pneg = 0;
    for (int i = 0; i < LANES; i++) act_b[i] = 8'd9;
    step();
    idle();

    // R2 R5 R12: loaded products over a sweep of bytes and zero points
    req = "R2 R5 R12 9-bit product load";
    op = 3'd1; clr = 1;
    for (int z = 0; z < 3; z++) begin
      for (int a = 0; a < 256; a += 15) begin
        for (int w = 0; w < 256; w += 51) begin
          zpa = (z == 0) ? 8'd0 : (z == 1) ? 8'd128 : 8'd255;
          zpw = 8'd255 - zpa;
          for (int i = 0; i < LANES; i++) begin
            act_b[i] = 8'(a + i * 37);
            wgt_b[i] = 8'(w + i * 11);
          end
          step();
        end
      end
    end

    // R2: accumulation across cycles
    req = "R2 9-bit accumulation";
    clr = 0; zpa = 8'd100; zpw = 8'd30;
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < LANES; i++) begin
        act_b[i] = 8'(k * 13 + i * 50);
        wgt_b[i] = 8'(k * 29 + i * 7);
      end
      step();
    end

    // R3 R4: 16-bit pairs driven into both clamps; odd lanes hold
    req = "R3 R4 16-bit saturation";
    mode16 = 1; op = 3'd1; zpa = 8'd77; zpw = 8'd77;
    act_b[0] = 8'hFF; act_b[1] = 8'h7F; act_b[2] = 8'h00; act_b[3] = 8'h80;
    for (int i = 0; i < LANES; i += 2) begin wgt_b[i] = 8'hFF; wgt_b[i+1] = 8'h7F; end
    for (int k = 0; k < 4; k++) begin clr = (k == 0); step(); end
    req = "R4 stays clamped";
    mode16 = 0; clr = 0; zpa = 0; op = 3'd2;
    act_b[0] = 8'd255; act_b[2] = 8'd0;
    step();
    op = 3'd3; act_b[0] = 8'd0; act_b[2] = 8'd255;
    step();

    // R6 R7 R11: add/sub/min/max/and/or with weights scrambled, then forwarded source
    for (int s = 0; s < 2; s++) begin
      src_fwd = s[0];
      for (int o = 2; o < 8; o++) begin
        req = (o < 6) ? "R6 R11 arithmetic ops" : "R7 R11 logic ops";
        op = 3'(o);
        for (int k = 0; k < 12; k++) begin
          clr = (k == 0);
          zpa = 8'(k * 21);
          for (int i = 0; i < LANES; i++) begin
            act_b[i] = 8'(k * 47 + i * 61 + o);
            fwd_b[i] = 8'(k * 83 + i * 19 + 5);
            wgt_b[i] = 8'(k * 97 + i);
          end
          step();
        end
      end
    end
    src_fwd = 0;

    // R8: no-op holds
    req = "R8 no-op hold";
    op = 3'd0; clr = 0;
    for (int i = 0; i < LANES; i++) act_b[i] = 8'hA5;
    step(); step();

    // R9 R10: predicates from known signs, then gated add
    for (int c = 0; c < 4; c++) begin
      for (int n = 0; n < 2; n++) begin
        req = "R9 R10 predicate set and gate";
        idle();
        op = 3'd2; clr = 1; zpa = 8'd100;
        act_b[0] = 8'd150; act_b[1] = 8'd100; act_b[2] = 8'd50; act_b[3] = 8'd200;
        step();
        idle();
        pred_wr = 1; pwi = 3'(c * 2 + n); pcond = 2'(c);
        step();
        idle();
        op = 3'd2; zpa = 8'd100; pen = 1; psel = 3'(c * 2 + n); pneg = n[0];
        for (int i = 0; i < LANES; i++) act_b[i] = 8'd103;
        step();
      end
    end

    // R9 R10: write and gate in the same cycle use the old bit
    req = "R9 R10 same-cycle write and gate";
    idle();
    op = 3'd2; zpa = 8'd0; pen = 1; psel = 3'd7; pneg = 1;
    pred_wr = 1; pwi = 3'd7; pcond = 2'd3;
    for (int i = 0; i < LANES; i++) act_b[i] = 8'd4;
    step();
    step();

    // near-exhaustive mixed stream against the model
    req = "R2 R3 R4 R6 R7 R9 R10 R11 mixed stream";
    for (int k = 0; k < 400; k++) begin
      op = 3'($urandom_range(0, 7)); clr = ($urandom_range(0, 5) == 0);
      mode16 = ($urandom_range(0, 3) == 0); src_fwd = $urandom_range(0, 1);
      zpa = 8'($urandom); zpw = 8'($urandom);
      pred_wr = $urandom_range(0, 1); pwi = 3'($urandom); pcond = 2'($urandom);
      pen = $urandom_range(0, 1); psel = 3'($urandom); pneg = $urandom_range(0, 1);
      for (int i = 0; i < LANES; i++) begin
        act_b[i] = 8'($urandom); wgt_b[i] = 8'($urandom); fwd_b[i] = 8'($urandom);
      end
      step();
    end

    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule